// File: doc/BRIEF.md
# Rolling-Shutter Readout Sequencer

This block produces the timing of a progressive-scan image sensor that uses a rolling shutter. It runs from a master clock. Rows are handled one after another. Each row receives a reset strobe and, a programmable number of row times later, a read strobe. That interval is the exposure. A pixel stream at half the master clock rate leaves the block. Each pixel carries a 10-bit data word, a line qualifier, a frame qualifier, a pixel-clock enable and a two-bit color tag that marks its position in a Bayer mosaic.

There is no pixel array or converter here. A synthetic data source stands in for them: each active pixel reports its column index plus its row index. A frame is made of the active rows followed by a programmable number of blanking rows. Every row is made of the active columns followed by a fixed horizontal blanking. The exposure and blanking inputs are sampled during reset and again at each frame boundary. A change made in the middle of a frame therefore waits for the next frame.

Top module: `readout_seq`

## Requirements
- R1: `pix_en` is high in every second master cycle once reset is released. `pix_data`, `line_valid`, `frame_valid` and `bayer_tag` hold their values across both master cycles of a pixel period.
- R2: In each active row, `line_valid` is high for exactly COLS consecutive pixel periods. It is then low for HBLANK pixel periods before the next row begins.
- R3: `frame_valid` is high during the ROWS active rows, and `line_valid` is never high while it is low. `frame_valid` is then low for V blanking rows, where V is the vblank input clamped to the range 1..MAX_VBLANK (0 acts as 1).
- R4: While `line_valid` is high, `pix_data` equals (column index + row index) mod 2^DATA_W, with both indices counted from 0. While `line_valid` is low, `pix_data` is 0.
- R5: `bayer_tag` = {row parity, column parity}. 0 marks green on a green/red row, 1 marks red, 2 marks blue, and 3 marks green on a blue/green row.
- R6: `row_read_stb` is high for exactly one master cycle at the start of each active row, with `row_read_addr` set to that row's index. Rows go 0..ROWS-1 in order. During blanking rows, `row_read_addr` keeps counting and the strobe stays low.
- R7: In the cycle that starts each row, `row_reset_addr` = (`row_read_addr` + E) mod T, where E is the effective exposure and T = ROWS + V. `row_reset_stb` is high in that cycle exactly when `row_reset_addr` < ROWS.
- R8: An exposure input of 0 acts as 1. An exposure input larger than T acts as T, so the reset and read addresses coincide.
- R9: Changes to the exposure and vblank inputs take effect exactly at the first row of the next frame. The current frame finishes with the old values.
- R10: While reset is asserted, `pix_en`, `line_valid`, `frame_valid` and both strobes are low. In the first cycle after the first clock edge following release, row 0 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exposure_rows | input | ROW_W | Exposure length in row times |
| vblank_rows | input | VB_W | Vertical blanking length in rows |
| pix_en | output | 1 | Pixel-clock enable, high in every second cycle |
| pix_data | output | DATA_W | Synthetic pixel value |
| line_valid | output | 1 | Pixel belongs to an active column of an active row |
| frame_valid | output | 1 | Active rows of the frame in progress |
| bayer_tag | output | 2 | Color tag {row parity, column parity} |
| row_reset_stb | output | 1 | Reset strobe for the row in `row_reset_addr` |
| row_reset_addr | output | ROW_W | Row addressed by the reset pointer |
| row_read_stb | output | 1 | Read strobe for the row in `row_read_addr` |
| row_read_addr | output | ROW_W | Row addressed by the read pointer |

## Verification
The bench builds the block with 8 columns, 6 rows, 2 blanking pixel periods and at most 7 blanking rows. A full frame then takes between 140 and 260 master cycles, so every pixel of several whole frames can be compared against a model in the bench. At this size the reset pointer wraps across the frame boundary for every exposure setting. The frame length can also be switched between 7, 8 and 13 rows. Exposures of 0, 1, full frame and beyond full frame, and a vblank of 0, are all reached with small inputs. Each of these changes is made in the middle of a frame, so the switch can be checked to land on the following frame boundary.

// File: rtl/readout_seq.sv
module readout_seq #(
  parameter int COLS       = 640,
  parameter int ROWS       = 480,
  parameter int HBLANK     = 16,
  parameter int MAX_VBLANK = 45,
  parameter int DATA_W     = 10,
  localparam int LINE      = COLS + HBLANK,
  localparam int COL_W     = $clog2(LINE),
  localparam int MAX_T     = ROWS + MAX_VBLANK,
  localparam int ROW_W     = $clog2(MAX_T + 1),
  localparam int VB_W      = $clog2(MAX_VBLANK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  exposure_rows,
  input  logic [VB_W-1:0]   vblank_rows,
  output logic              pix_en,
  output logic [DATA_W-1:0] pix_data,
  output logic              line_valid,
  output logic              frame_valid,
  output logic [1:0]        bayer_tag,
  output logic              row_reset_stb,
  output logic [ROW_W-1:0]  row_reset_addr,
  output logic              row_read_stb,
  output logic [ROW_W-1:0]  row_read_addr
);

  logic             run_q, phase_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q, exp_q;
  logic [VB_W-1:0]  vbl_q;

  logic [VB_W-1:0]  vbl_eff;
  logic [ROW_W-1:0] total_in, exp_eff, total_q, rst_ptr;
  logic [ROW_W:0]   lead_sum;
  logic             tick, line_end, frame_end, active, line_start;

  assign vbl_eff  = (vblank_rows == '0) ? VB_W'(1) :
                    (vblank_rows > VB_W'(MAX_VBLANK)) ? VB_W'(MAX_VBLANK) : vblank_rows;
  assign total_in = ROW_W'(ROWS) + ROW_W'(vbl_eff);
  assign exp_eff  = (exposure_rows == '0) ? ROW_W'(1) :
                    (exposure_rows > total_in) ? total_in : exposure_rows;

  assign total_q   = ROW_W'(ROWS) + ROW_W'(vbl_q);
  assign tick      = run_q & phase_q;
  assign line_end  = (col_q == COL_W'(LINE - 1));
  assign frame_end = line_end && (row_q == total_q - ROW_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      col_q   <= '0;
      row_q   <= '0;
      exp_q   <= exp_eff;
      vbl_q   <= vbl_eff;
    end else begin
      run_q <= 1'b1;
      if (run_q) phase_q <= ~phase_q;
      if (tick) begin
        if (line_end) begin
          col_q <= '0;
          row_q <= frame_end ? '0 : row_q + ROW_W'(1);
        end else begin
          col_q <= col_q + COL_W'(1);
        end
        if (frame_end) begin
          exp_q <= exp_eff;
          vbl_q <= vbl_eff;
        end
      end
    end
  end

  assign lead_sum = {1'b0, row_q} + {1'b0, exp_q};
  assign rst_ptr  = (lead_sum >= {1'b0, total_q}) ? ROW_W'(lead_sum - {1'b0, total_q})
                                                   : ROW_W'(lead_sum);

  assign active     = run_q && (row_q < ROW_W'(ROWS));
  assign line_start = run_q && !phase_q && (col_q == '0);

  assign pix_en         = tick;
  assign frame_valid    = active;
  assign line_valid     = active && (col_q < COL_W'(COLS));
  assign pix_data       = line_valid ? (DATA_W'(col_q) + DATA_W'(row_q)) : '0;
  assign bayer_tag      = {row_q[0], col_q[0]};
  assign row_read_addr  = row_q;
  assign row_read_stb   = line_start && (row_q < ROW_W'(ROWS));
  assign row_reset_addr = rst_ptr;
  assign row_reset_stb  = line_start && (rst_ptr < ROW_W'(ROWS));

  p_pix_alternate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (pix_en != $past(pix_en)));

  p_pix_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> ($stable(pix_data) && $stable(line_valid) && $stable(bayer_tag)));

  p_lv_inside_fv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> frame_valid);

  p_read_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_read_stb |=> !row_read_stb);

  p_reset_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    row_reset_stb |=> !row_reset_stb);

  p_bayer_even_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !row_read_addr[0]) |-> !bayer_tag[1]);

  p_setting_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(exp_q) || !$stable(vbl_q)) |-> (row_q == '0 && col_q == '0));

endmodule

// File: tb/readout_seq_test.sv
module readout_seq_test;
  localparam int COLS = 8, ROWS = 6, HBLANK = 2, MAXV = 7, DW = 10;
  localparam int LINE = COLS + HBLANK;
  localparam int ROW_W = $clog2(ROWS + MAXV + 1);
  localparam int VB_W = $clog2(MAXV + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ROW_W-1:0] exposure_rows = '0;
  logic [VB_W-1:0]  vblank_rows = '0;
  logic pix_en, line_valid, frame_valid, row_reset_stb, row_read_stb;
  logic [DW-1:0] pix_data;
  logic [1:0] bayer_tag;
  logic [ROW_W-1:0] row_reset_addr, row_read_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  readout_seq #(.COLS(COLS), .ROWS(ROWS), .HBLANK(HBLANK), .MAX_VBLANK(MAXV), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .exposure_rows(exposure_rows), .vblank_rows(vblank_rows),
    .pix_en(pix_en), .pix_data(pix_data), .line_valid(line_valid), .frame_valid(frame_valid),
    .bayer_tag(bayer_tag), .row_reset_stb(row_reset_stb), .row_reset_addr(row_reset_addr),
    .row_read_stb(row_read_stb), .row_read_addr(row_read_addr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Checks one whole frame that starts in the current (negedge) sample.
  // Optionally drives new settings mid-frame at sample chg_at.
  task automatic run_frame(input int e, input int t, input int chg_at, input int ne, input int nv);
    for (int cyc = 0; cyc < 2 * LINE * t; cyc++) begin
      int p = cyc / 2;
      int ln = p / LINE;
      int col = p % LINE;
      bit lv = (ln < ROWS) && (col < COLS);
      bit first = (cyc % (2 * LINE)) == 0;
      int ra = (ln + e) % t;
      if (cyc == chg_at) begin
        exposure_rows = ROW_W'(ne);
        vblank_rows = VB_W'(nv);
      end
      chk(pix_en == (cyc % 2), "R1 pix_en", pix_en, cyc % 2);
      chk(line_valid == lv, "R2 line_valid", line_valid, lv);
      chk(frame_valid == (ln < ROWS), "R3 frame_valid", frame_valid, ln < ROWS);
      chk(pix_data == (lv ? (col + ln) % (1 << DW) : 0), "R4 pix_data", pix_data,
          lv ? (col + ln) % (1 << DW) : 0);
      if (lv) chk(bayer_tag == {ln[0], col[0]}, "R5 bayer_tag", bayer_tag, {ln[0], col[0]});
      chk(row_read_stb == (first && ln < ROWS), "R6 read strobe", row_read_stb, first && ln < ROWS);
      if (first) begin
        chk(row_read_addr == ln, "R6 read addr", row_read_addr, ln);
        chk(row_reset_addr == ra, "R7 reset addr", row_reset_addr, ra);
        chk(row_reset_stb == (ra < ROWS), "R7 reset strobe", row_reset_stb, ra < ROWS);
      end else begin
        chk(row_reset_stb == 1'b0, "R7 reset strobe idle", row_reset_stb, 0);
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    exposure_rows = 3; vblank_rows = 2; rst_n = 0;
    repeat (4) @(negedge clk);
    chk(!pix_en && !line_valid && !frame_valid, "R10 outputs in reset",
        {pix_en, line_valid, frame_valid}, 0);
    chk(!row_read_stb && !row_reset_stb, "R10 strobes in reset", {row_read_stb, row_reset_stb}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(row_read_stb && row_read_addr == 0, "R10 first read is row 0", row_read_addr, 0);
  endtask

  // Exposure 3, T=8; mid-frame switch to exposure 1, vblank 1 (R9)
  task automatic t_main;
    run_frame(3, 8, 2 * LINE * 2 + 5, 1, 1);
  endtask

  // R8/R3: exposure 0 and vblank 0 clamp to 1 each
  task automatic t_min_settings;
    run_frame(1, 7, 2 * LINE * 3 + 1, 0, 0);
    run_frame(1, 7, 2 * LINE * 4 + 3, 15, 2);
  endtask

  // R8: exposure above T clamps to full frame, reset row equals read row
  task automatic t_full_exposure;
    run_frame(8, 8, 2 * LINE * 1 + 7, 7, 7);
  endtask

  // R3/R7: long vertical blanking, reset pointer wraps over blank rows
  task automatic t_long_vblank;
    run_frame(7, 13, 2 * LINE * 9 + 1, 7, 7);
    run_frame(7, 13, -1, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_main;
    t_min_settings;
    t_full_exposure;
    t_long_vblank;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule